// File: doc/BRIEF.md
# Interrupt-capable GPIO controller

A 32-pin general-purpose I/O block for a simple 32-bit register bus in the APB style. Software picks which pins drive their pads. It updates the output word directly or with atomic bit set and bit clear writes. It reads back the synchronised input levels. The pads themselves sit outside the block and are seen only as three vectors: incoming level, outgoing value and output enable.

Each pin can raise an interrupt. Three configuration bits per pin choose the condition. A sense bit picks edge or level. A both-edges bit picks any edge over one edge. A polarity bit picks rising edges or high levels against falling edges or low levels. Each pin also has an enable bit and a mask bit. Latched edge events are cleared by writing ones to an acknowledge register. All pins share one interrupt line. Any pin can put its input through a debounce filter whose hold time is programmable.

A bus write takes effect at the clock edge where select, enable and write are all high. Read data is combinational from the address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: All registers reset to zero except the debounce length. Each bit of the direction register (byte offset 0x00) drives the matching `pad_oe` bit: 0 makes the pin an input, 1 makes it an output.
- R2: A write to the set register (0x08) forces to 1 every output bit whose data bit is 1. A write to the clear register (0x0C) forces those bits to 0. Data bits that are 0 leave the output unchanged.
- R3: The output data register (0x10) can be written and read directly, and its value appears on `pad_out`.
- R4: Input data (0x14) returns the filtered pad level. With debounce off, a pad change made before clock edge k can be read after edge k+2.
- R5: For a pin with sense 0 (0x1C) and both-edges 0 (0x20), a polarity bit (0x24) of 1 latches rising edges and 0 latches falling edges. The raw status bit (0x28) is set after edge k+3 for a pad change made before edge k.
- R6: With sense 0 and both-edges 1, either edge is latched whatever the polarity bit holds.
- R7: With sense 1, the raw status bit shows live whether the filtered input equals the polarity bit (1 means high, 0 means low). It is not latched, and acknowledge writes do not affect it.
- R8: A pin whose enable bit (0x18) is 0 produces no raw status.
- R9: Masked status (0x30) equals raw status AND NOT mask (0x2C). `irq` is the OR of the masked status bits. Raw status is unaffected by the mask.
- R10: Writing 1 to a bit of the acknowledge register (0x34) clears that pin's latched edge. Bits written 0 have no effect. An edge that arrives in the same cycle as its clear stays latched.
- R11: When a pin's debounce enable bit (0x38) is 1, a new level is accepted only after the synchronised input has held it for N consecutive clocks. N is the debounce length (0x3C). It resets to 16, and 0 behaves as 1. Pins with the bit at 0 are not filtered.
- R12: The reserved control word (0x04) and the write-only set, clear and acknowledge words read as zero, and writes to the control word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register bus select |
| bus_enable | input | 1 | Access phase of a transfer |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
Each result is due at a fixed point after its stimulus. A register write is visible from the cycle after its access-phase edge. An input pad change is readable after the third clock edge and has latched an edge status after the fourth. Level status follows after the third edge. With debounce on, acceptance comes on the N-th clock after the synchronised level changes. The latency test holds the read address steady and samples on falling edges, so it can show the value is still old one cycle before each due edge and new at it. The test where an acknowledge and an edge arrive together places the access phase of the write on exactly the edge that latches. The other tests wait well past the due cycle and then sample.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  localparam int BUS_AW = 8;

  localparam logic [BUS_AW-1:0] A_DIR   = 8'h00;
  localparam logic [BUS_AW-1:0] A_CTRL  = 8'h04;
  localparam logic [BUS_AW-1:0] A_SET   = 8'h08;
  localparam logic [BUS_AW-1:0] A_CLR   = 8'h0C;
  localparam logic [BUS_AW-1:0] A_OUT   = 8'h10;
  localparam logic [BUS_AW-1:0] A_IN    = 8'h14;
  localparam logic [BUS_AW-1:0] A_IEN   = 8'h18;
  localparam logic [BUS_AW-1:0] A_SENSE = 8'h1C;
  localparam logic [BUS_AW-1:0] A_BOTH  = 8'h20;
  localparam logic [BUS_AW-1:0] A_POL   = 8'h24;
  localparam logic [BUS_AW-1:0] A_RAW   = 8'h28;
  localparam logic [BUS_AW-1:0] A_MASK  = 8'h2C;
  localparam logic [BUS_AW-1:0] A_MIS   = 8'h30;
  localparam logic [BUS_AW-1:0] A_ACK   = 8'h34;
  localparam logic [BUS_AW-1:0] A_DBEN  = 8'h38;
  localparam logic [BUS_AW-1:0] A_DBCFG = 8'h3C;

  // Edge qualifies when the level moved and either any edge is wanted
  // or the new level equals the chosen polarity.
  function automatic logic f_edge_hit(input logic prev, input logic cur,
                                      input logic both, input logic pol);
    return (prev != cur) && (both || (cur == pol));
  endfunction

  function automatic logic f_level_hit(input logic cur, input logic pol);
    return cur == pol;
  endfunction

  // Debounce accepts on the clock where the differing level has been
  // seen lim times (lim of 0 counts as 1).
  function automatic logic f_db_done(input logic [15:0] cnt, input logic [15:0] lim);
    return (cnt + 16'd1) >= lim;
  endfunction

endpackage

// File: rtl/gpio_in_filter.sv
`timescale 1ns/1ps
module gpio_in_filter
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int DBW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] db_en,
  input  logic [DBW-1:0]  db_lim,
  output logic [NPIN-1:0] level
);

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic           s1_q, s2_q, filt_q;
    logic [DBW-1:0] cnt_q;
    logic           done;

    assign done = f_db_done(16'(cnt_q), 16'(db_lim));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        filt_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        s1_q <= pad_in[g];
        s2_q <= s1_q;
        if (!db_en[g]) begin
          filt_q <= s2_q;
          cnt_q  <= '0;
        end else if (s2_q == filt_q) begin
          cnt_q <= '0;
        end else if (done) begin
          filt_q <= s2_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign level[g] = filt_q;
  end

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] level,
  input  logic [NPIN-1:0] ien,
  input  logic [NPIN-1:0] sense,
  input  logic [NPIN-1:0] both,
  input  logic [NPIN-1:0] pol,
  input  logic [NPIN-1:0] ack,
  output logic [NPIN-1:0] edge_evt,
  output logic [NPIN-1:0] edge_latched,
  output logic [NPIN-1:0] raw
);

  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] lvl_hit;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    assign edge_evt[g] = ien[g] & ~sense[g]
                       & f_edge_hit(prev_q[g], level[g], both[g], pol[g]);
    assign lvl_hit[g]  = ien[g] & sense[g] & f_level_hit(level[g], pol[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q       <= '0;
      edge_latched <= '0;
    end else begin
      prev_q       <= level;
      edge_latched <= (edge_latched & ~ack) | edge_evt;
    end
  end

  assign raw = lvl_hit | (edge_latched & ~sense);

endmodule

// File: rtl/gpio_regbank.sv
`timescale 1ns/1ps
module gpio_regbank
  import gpio_irq_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int DBW    = 8,
  parameter int DB_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   in_level,
  input  logic [NPIN-1:0]   raw,
  input  logic [NPIN-1:0]   mis,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   dout_q,
  output logic [NPIN-1:0]   ien_q,
  output logic [NPIN-1:0]   sense_q,
  output logic [NPIN-1:0]   both_q,
  output logic [NPIN-1:0]   pol_q,
  output logic [NPIN-1:0]   mask_q,
  output logic [NPIN-1:0]   dben_q,
  output logic [DBW-1:0]    dblim_q,
  output logic [NPIN-1:0]   ack
);

  logic wr_acc;
  assign wr_acc = bus_sel & bus_enable & bus_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      dout_q  <= '0;
      ien_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
      dben_q  <= '0;
      dblim_q <= DBW'(DB_RST);
    end else if (wr_acc) begin
      case (bus_addr)
        A_DIR:   dir_q   <= bus_wdata;
        A_SET:   dout_q  <= dout_q | bus_wdata;
        A_CLR:   dout_q  <= dout_q & ~bus_wdata;
        A_OUT:   dout_q  <= bus_wdata;
        A_IEN:   ien_q   <= bus_wdata;
        A_SENSE: sense_q <= bus_wdata;
        A_BOTH:  both_q  <= bus_wdata;
        A_POL:   pol_q   <= bus_wdata;
        A_MASK:  mask_q  <= bus_wdata;
        A_DBEN:  dben_q  <= bus_wdata;
        A_DBCFG: dblim_q <= bus_wdata[DBW-1:0];
        default: ;
      endcase
    end
  end

  assign ack = (wr_acc && bus_addr == A_ACK) ? bus_wdata : '0;

  always_comb begin
    case (bus_addr)
      A_DIR:   bus_rdata = dir_q;
      A_OUT:   bus_rdata = dout_q;
      A_IN:    bus_rdata = in_level;
      A_IEN:   bus_rdata = ien_q;
      A_SENSE: bus_rdata = sense_q;
      A_BOTH:  bus_rdata = both_q;
      A_POL:   bus_rdata = pol_q;
      A_RAW:   bus_rdata = raw;
      A_MASK:  bus_rdata = mask_q;
      A_MIS:   bus_rdata = mis;
      A_DBEN:  bus_rdata = dben_q;
      A_DBCFG: bus_rdata = {{(NPIN-DBW){1'b0}}, dblim_q};
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int DBW    = 8,
  parameter int DB_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic              irq
);

  logic [NPIN-1:0] dir_q, dout_q, ien_q, sense_q, both_q, pol_q, mask_q, dben_q;
  logic [DBW-1:0]  dblim_q;
  logic [NPIN-1:0] ack, in_level, edge_evt, edge_latched, raw, mis;

  gpio_regbank #(.NPIN(NPIN), .DBW(DBW), .DB_RST(DB_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_level(in_level), .raw(raw), .mis(mis),
    .dir_q(dir_q), .dout_q(dout_q), .ien_q(ien_q), .sense_q(sense_q),
    .both_q(both_q), .pol_q(pol_q), .mask_q(mask_q), .dben_q(dben_q),
    .dblim_q(dblim_q), .ack(ack)
  );

  gpio_in_filter #(.NPIN(NPIN), .DBW(DBW)) u_filt (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .db_en(dben_q), .db_lim(dblim_q), .level(in_level)
  );

  gpio_irq_detect #(.NPIN(NPIN)) u_det (
    .clk(clk), .rst_n(rst_n), .level(in_level),
    .ien(ien_q), .sense(sense_q), .both(both_q), .pol(pol_q), .ack(ack),
    .edge_evt(edge_evt), .edge_latched(edge_latched), .raw(raw)
  );

  assign mis     = raw & ~mask_q;
  assign irq     = |mis;
  assign pad_out = dout_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_enable,
  input logic              bus_write,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_wdata,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe,
  input logic              irq,
  input logic [NPIN-1:0]   mask_q,
  input logic [NPIN-1:0]   edge_evt,
  input logic [NPIN-1:0]   edge_latched
);

  logic wr_acc;
  assign wr_acc = bus_sel & bus_enable & bus_write;

  p_dir_to_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && bus_addr == A_DIR) |=> (pad_oe == $past(bus_wdata)));

  p_set_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && bus_addr == A_SET) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)));

  p_clr_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && bus_addr == A_CLR) |=> ((pad_out & $past(bus_wdata)) == '0));

  p_full_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);

  p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_evt) |=> (($past(edge_evt) & ~edge_latched) == '0));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq),
  .mask_q(mask_q), .edge_evt(edge_evt), .edge_latched(edge_latched)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;

  localparam logic [7:0] O_DIR = 8'h00, O_CTRL = 8'h04, O_SET = 8'h08, O_CLR = 8'h0C;
  localparam logic [7:0] O_OUT = 8'h10, O_IN = 8'h14, O_IEN = 8'h18, O_SENSE = 8'h1C;
  localparam logic [7:0] O_BOTH = 8'h20, O_POL = 8'h24, O_RAW = 8'h28, O_MASK = 8'h2C;
  localparam logic [7:0] O_MIS = 8'h30, O_ACK = 8'h34, O_DBEN = 8'h38, O_DBCFG = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, en = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pad_out, pad_oe;
  logic [31:0] pad_in = '0;
  logic        irq;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(sel), .bus_enable(en), .bus_write(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; en = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    sel = 1'b0; en = 1'b0; wr = 1'b0;
  endtask

  task automatic rd32(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; en = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic setup_irq(input logic [31:0] ie, input logic [31:0] se,
                           input logic [31:0] bo, input logic [31:0] po);
    wr32(O_IEN, ie);
    wr32(O_SENSE, se);
    wr32(O_BOTH, bo);
    wr32(O_POL, po);
    wr32(O_ACK, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd32(O_DIR, d);   chk("R1 dir reset", d, 32'h0);
    chk("R1 pad_oe reset", pad_oe, 32'h0);
    rd32(O_MASK, d);  chk("R9 mask reset", d, 32'h0);
    rd32(O_IEN, d);   chk("R8 enable reset", d, 32'h0);
    rd32(O_DBCFG, d); chk("R11 debounce length reset", d, 32'd16);
    chk("R9 irq reset", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_outputs;
    logic [31:0] d;
    wr32(O_DIR, 32'h0000_FFFF);
    chk("R1 pad_oe follows dir", pad_oe, 32'h0000_FFFF);
    wr32(O_OUT, 32'h0000_00F0);
    wr32(O_SET, 32'h0000_000F);
    rd32(O_OUT, d); chk("R2 set bits", d, 32'h0000_00FF);
    wr32(O_CLR, 32'h0000_0030);
    rd32(O_OUT, d); chk("R2 clear bits", d, 32'h0000_00CF);
    chk("R3 pad_out", pad_out, 32'h0000_00CF);
    wr32(O_CTRL, 32'hFFFF_FFFF);
    rd32(O_CTRL, d); chk("R12 control reads zero", d, 32'h0);
    rd32(O_SET, d);  chk("R12 set reads zero", d, 32'h0);
    rd32(O_ACK, d);  chk("R12 ack reads zero", d, 32'h0);
    rd32(O_OUT, d);  chk("R12 control write no effect", d, 32'h0000_00CF);
    wr32(O_DIR, 32'h0);
  endtask

  task automatic t_latency;
    setup_irq(32'h1, 32'h0, 32'h0, 32'h1);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; en = 1'b0; addr = O_IN;
    pad_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R4 input not yet after 2 edges", rdata & 32'h1, 32'h0);
    @(negedge clk);
    chk("R4 input after 3 edges", rdata & 32'h1, 32'h1);
    chk("R5 rise not latched after 3 edges", {31'd0, irq}, 32'h0);
    @(negedge clk);
    chk("R5 rise latched after 4 edges", {31'd0, irq}, 32'h1);
    sel = 1'b0;
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr32(O_MASK, 32'h1);
    chk("R9 masked irq low", {31'd0, irq}, 32'h0);
    rd32(O_MIS, d); chk("R9 masked status zero", d & 32'h1, 32'h0);
    rd32(O_RAW, d); chk("R9 raw ignores mask", d & 32'h1, 32'h1);
    wr32(O_MASK, 32'h0);
    chk("R9 unmasked irq high", {31'd0, irq}, 32'h1);
    rd32(O_MIS, d); chk("R9 masked status set", d & 32'h1, 32'h1);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr32(O_ACK, 32'hFFFF_FFFE);
    rd32(O_RAW, d); chk("R10 zero bits keep status", d & 32'h1, 32'h1);
    wr32(O_ACK, 32'h1);
    rd32(O_RAW, d); chk("R10 one bit clears", d & 32'h1, 32'h0);
    chk("R10 irq after clear", {31'd0, irq}, 32'h0);
    pad_in[0] = 1'b0;
    setup_irq(32'h8, 32'h0, 32'h0, 32'h8);
    @(negedge clk);
    pad_in[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; en = 1'b0; addr = O_ACK; wdata = 32'h8;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    sel = 1'b0; en = 1'b0; wr = 1'b0;
    rd32(O_RAW, d); chk("R10 edge wins over clear", d & 32'h8, 32'h8);
    wr32(O_ACK, 32'h8);
    rd32(O_RAW, d); chk("R10 later clear", d & 32'h8, 32'h0);
    pad_in = '0;
    cyc(6);
  endtask

  task automatic t_falling;
    logic [31:0] d;
    setup_irq(32'h2, 32'h0, 32'h0, 32'h0);
    pad_in[1] = 1'b1; cyc(6);
    rd32(O_RAW, d); chk("R5 falling ignores rise", d & 32'h2, 32'h0);
    pad_in[1] = 1'b0; cyc(6);
    rd32(O_RAW, d); chk("R5 falling latched", d & 32'h2, 32'h2);
  endtask

  task automatic t_both;
    logic [31:0] d;
    setup_irq(32'h4, 32'h0, 32'h4, 32'h0);
    pad_in[2] = 1'b1; cyc(6);
    rd32(O_RAW, d); chk("R6 both rise", d & 32'h4, 32'h4);
    wr32(O_ACK, 32'h4);
    pad_in[2] = 1'b0; cyc(6);
    rd32(O_RAW, d); chk("R6 both fall", d & 32'h4, 32'h4);
  endtask

  task automatic t_level;
    logic [31:0] d;
    setup_irq(32'h30, 32'h30, 32'h0, 32'h10);
    cyc(2);
    rd32(O_RAW, d); chk("R7 low level active", d & 32'h30, 32'h20);
    pad_in[4] = 1'b1; cyc(6);
    rd32(O_RAW, d); chk("R7 high level active", d & 32'h30, 32'h30);
    wr32(O_ACK, 32'h30);
    rd32(O_RAW, d); chk("R7 ack no effect on level", d & 32'h30, 32'h30);
    pad_in[4] = 1'b0; pad_in[5] = 1'b1; cyc(6);
    rd32(O_RAW, d); chk("R7 level not latched", d & 32'h30, 32'h0);
    pad_in = '0;
    cyc(6);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    setup_irq(32'h0, 32'h0, 32'h0, 32'h40);
    pad_in[6] = 1'b1; cyc(2); pad_in[6] = 1'b0; cyc(6);
    rd32(O_RAW, d); chk("R8 disabled pin silent", d & 32'h40, 32'h0);
    wr32(O_IEN, 32'h40);
    pad_in[6] = 1'b1; cyc(2); pad_in[6] = 1'b0; cyc(6);
    rd32(O_RAW, d); chk("R8 enabled pin latches", d & 32'h40, 32'h40);
  endtask

  task automatic t_debounce;
    logic [31:0] d;
    wr32(O_DBCFG, 32'd4);
    wr32(O_DBEN, 32'h80);
    setup_irq(32'h180, 32'h0, 32'h0, 32'h180);
    pad_in[7] = 1'b1; cyc(3); pad_in[7] = 1'b0; cyc(12);
    rd32(O_RAW, d); chk("R11 short pulse rejected", d & 32'h80, 32'h0);
    pad_in[7] = 1'b1; cyc(4); pad_in[7] = 1'b0; cyc(12);
    rd32(O_RAW, d); chk("R11 held pulse accepted", d & 32'h80, 32'h80);
    pad_in[8] = 1'b1; cyc(1); pad_in[8] = 1'b0; cyc(6);
    rd32(O_RAW, d); chk("R11 unfiltered pin passes", d & 32'h100, 32'h100);
    wr32(O_DBCFG, 32'd0);
    wr32(O_ACK, 32'hFFFF_FFFF);
    pad_in[7] = 1'b1; cyc(1); pad_in[7] = 1'b0; cyc(6);
    rd32(O_RAW, d); chk("R11 length zero acts as one", d & 32'h80, 32'h80);
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_outputs();
    t_latency();
    t_mask();
    t_clear();
    t_falling();
    t_both();
    t_level();
    t_enable();
    t_debounce();
    finish_up();
  end

endmodule